// File: doc/BRIEF.md
# Parallel Port Interrupt Controller

This block gathers five interrupt sources around a parallel port and folds them into one host interrupt line. The sources are peripheral disconnection, any change on a peripheral-driven status line, bulk-in data becoming available, the bulk-out path draining to empty, and a falling fault line while the port runs in ECP mode. Each source latches a sticky pending bit whatever its mask says. The interrupt output is asserted while any pending bit has its mask bit cleared. Software clears a pending bit by writing 1 to it.

An 8-bit control register holds the five masks, a reserved bit, a compression enable and an automatic mode bit. The last two are also driven out to neighbouring engines. While automatic mode is on, only the control register accepts writes. The pending and data registers become read-only.

Clearing automatic mode gives write access back only if no automatic transfer has yet been reported on the activity strobe. Disconnection is seen in two ways: the logic-high line falls, or every peripheral-driven line stays high for a parameterised number of cycles. In the second case the event fires once per high period.

Top module: `pport_irq_ctrl`

## Requirements
- R1: After reset the control register (address 0) reads 8'hFB, the pending register (address 1) and the data register (address 2) read 0, irq is 0, and auto_mode and compress_en are 1.
- R2: The control register at address 0 accepts writes of all eight bits at all times, reads back what was written, and is laid out as bit 7 disconnect mask, 6 change mask, 5 bulk-in mask, 4 bulk-out mask, 3 fault mask, 2 reserved (software writes 0), 1 compress_en, 0 auto_mode.
- R3: Any rising or falling transition on any periph_lines bit or on periph_logic_high sets pending bit 3 (change). The bit is visible on the third rising edge after the input moves.
- R4: A 1-to-0 transition of periph_logic_high sets pending bit 4 (disconnect), visible on the third rising edge after the input moves.
- R5: When all periph_lines bits and periph_logic_high are high, pending bit 4 is set on rising edge TIMEOUT+2 after they all rise. The event does not fire again until some line has gone low and the lines have then stayed high for another full timeout.
- R6: A rising bulk_in_avail sets pending bit 2, and a rising bulk_out_empty sets pending bit 1, each on the first rising edge that samples the new level.
- R7: A falling edge on periph_lines[FAULT_BIT] sets pending bit 0 only while port_mode is 3'b011. In any other mode it leaves bit 0 unchanged.
- R8: Pending bits are set whether or not they are masked. irq is 1 exactly when some pending bit i (bits 4..0) is 1 while control bit i+3 is 0.
- R9: Writing to address 1 clears each pending bit whose write-data bit is 1 and leaves the others alone. A new event in the same cycle wins over the clear.
- R10: While auto_mode is 1, writes to addresses 1 and 2 are ignored. With auto_mode at 0 and no recorded activity, address 2 stores and reads back a byte.
- R11: An auto_activity pulse while auto_mode is 1 is remembered until reset. From then on, clearing auto_mode does not unlock writes to addresses 1 and 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 pending, 2 data, 3 reads 0 |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| port_mode | input | 3 | Current parallel port mode; 3'b011 is ECP |
| periph_lines | input | LINES | Asynchronous status lines driven by the peripheral |
| periph_logic_high | input | 1 | Asynchronous peripheral logic-high line |
| bulk_in_avail | input | 1 | Bulk-in data available flag |
| bulk_out_empty | input | 1 | Bulk-out path empty flag |
| auto_activity | input | 1 | Strobe marking an automatic transfer |
| irq | output | 1 | Host interrupt |
| compress_en | output | 1 | Control bit 1 |
| auto_mode | output | 1 | Control bit 0 |

## Verification
Changes on peripheral lines pass through two synchroniser flops and an edge flop. Their pending bits are therefore due on the third rising edge. The bench samples them one edge before that edge, where they must still be clear, and again on it.

Bulk flag events land on the first edge. Register writes and write-one-clears take effect on the edge under the strobe, and irq follows the pending and mask state with no further delay. The timeout disconnect is checked at edge TIMEOUT+1, where it must still be clear, at edge TIMEOUT+2, where it must be set, and again twenty cycles after it is cleared, where it must not have fired a second time. All inputs change at the falling edge and every read is taken just after a falling edge.

// File: rtl/pport_irq_pkg.sv
package pport_irq_pkg;

    // One bit per interrupt source; order matches mask bits 7..3 of control
    typedef struct packed {
        logic disc;
        logic chg;
        logic bin;
        logic bout;
        logic fault;
    } src_t;

    typedef struct packed {
        src_t mask;
        logic rsvd;
        logic comp_en;
        logic auto_en;
    } ctrl_t;

    localparam logic [7:0] CTRL_RESET = 8'hFB;
    localparam logic [2:0] MODE_ECP   = 3'b011;

    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_PEND = 2'd1,
        SEL_DATA = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    function automatic logic any_unmasked(input src_t pend, input src_t mask);
        logic [4:0] p;
        logic [4:0] m;
        p = pend;
        m = mask;
        return |(p & ~m);
    endfunction

endpackage

// File: rtl/ppic_sync.sv
module ppic_sync #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] raw,
    output logic [W-1:0] level,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;
    logic [W-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= raw;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign level = sync_q;

    for (genvar i = 0; i < W; i++) begin : g_edge
        assign rise[i] = sync_q[i] & ~prev_q[i];
        assign fall[i] = ~sync_q[i] & prev_q[i];
    end
endmodule

// File: rtl/ppic_timeout.sv
module ppic_timeout #(
    parameter int TIMEOUT = 1000000
) (
    input  logic clk,
    input  logic rst,
    input  logic all_high,
    output logic fire
);
    localparam int CW = $clog2(TIMEOUT + 1);
    localparam logic [CW-1:0] LIMIT = CW'(TIMEOUT);
    localparam logic [CW-1:0] LAST  = CW'(TIMEOUT - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !all_high) begin
            cnt_q <= '0;
        end else if (cnt_q != LIMIT) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Fires once: the counter parks at LIMIT until a line goes low
    assign fire = all_high && (cnt_q == LAST);
endmodule

// File: rtl/ppic_regs.sv
module ppic_regs
    import pport_irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr,
    input  logic [1:0] addr,
    input  logic [7:0] wdata,
    input  src_t       events,
    input  logic       act_strobe,
    output logic [7:0] rdata,
    output ctrl_t      ctrl,
    output src_t       pend,
    output logic [7:0] data,
    output logic       act_seen,
    output logic       locked
);
    reg_sel_e sel;
    logic [4:0] clr;
    logic [4:0] ev_v;
    logic [4:0] pend_v;

    assign sel    = reg_sel_e'(addr);
    assign locked = ctrl.auto_en | act_seen;
    assign clr    = (wr && sel == SEL_PEND && !locked) ? wdata[4:0] : 5'd0;
    assign ev_v   = events;
    assign pend_v = pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl     <= ctrl_t'(CTRL_RESET);
            pend     <= '0;
            data     <= '0;
            act_seen <= 1'b0;
        end else begin
            if (act_strobe && ctrl.auto_en) act_seen <= 1'b1;
            if (wr && sel == SEL_CTRL) ctrl <= ctrl_t'(wdata);
            if (wr && sel == SEL_DATA && !locked) data <= wdata;
            pend <= src_t'((pend_v & ~clr) | ev_v);
        end
    end

    always_comb begin
        unique case (sel)
            SEL_CTRL: rdata = ctrl;
            SEL_PEND: rdata = {3'b000, pend_v};
            SEL_DATA: rdata = data;
            default:  rdata = 8'h00;
        endcase
    end
endmodule

// File: rtl/pport_irq_ctrl.sv
module pport_irq_ctrl
    import pport_irq_pkg::*;
#(
    parameter int LINES     = 5,
    parameter int FAULT_BIT = 1,
    parameter int TIMEOUT   = 1000000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_wr,
    input  logic [1:0]       reg_addr,
    input  logic [7:0]       reg_wdata,
    output logic [7:0]       reg_rdata,
    input  logic [2:0]       port_mode,
    input  logic [LINES-1:0] periph_lines,
    input  logic             periph_logic_high,
    input  logic             bulk_in_avail,
    input  logic             bulk_out_empty,
    input  logic             auto_activity,
    output logic             irq,
    output logic             compress_en,
    output logic             auto_mode
);
    localparam int SW = LINES + 1;   // lines plus logic-high at the top

    logic [SW-1:0] s_level;
    logic [SW-1:0] s_rise;
    logic [SW-1:0] s_fall;
    logic          tmo_fire;
    logic          bin_prev_q;
    logic          bout_prev_q;
    src_t          events;
    ctrl_t         ctrl_q;
    src_t          pend_q;
    logic [7:0]    data_q;
    logic          act_seen_q;
    logic          locked;

    ppic_sync #(.W(SW)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .raw   ({periph_logic_high, periph_lines}),
        .level (s_level),
        .rise  (s_rise),
        .fall  (s_fall)
    );

    ppic_timeout #(.TIMEOUT(TIMEOUT)) u_tmo (
        .clk      (clk),
        .rst      (rst),
        .all_high (&s_level),
        .fire     (tmo_fire)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            bin_prev_q  <= 1'b0;
            bout_prev_q <= 1'b0;
        end else begin
            bin_prev_q  <= bulk_in_avail;
            bout_prev_q <= bulk_out_empty;
        end
    end

    always_comb begin
        events.disc  = s_fall[SW-1] | tmo_fire;
        events.chg   = |(s_rise | s_fall);
        events.bin   = bulk_in_avail & ~bin_prev_q;
        events.bout  = bulk_out_empty & ~bout_prev_q;
        events.fault = s_fall[FAULT_BIT] && (port_mode == MODE_ECP);
    end

    ppic_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr         (reg_wr),
        .addr       (reg_addr),
        .wdata      (reg_wdata),
        .events     (events),
        .act_strobe (auto_activity),
        .rdata      (reg_rdata),
        .ctrl       (ctrl_q),
        .pend       (pend_q),
        .data       (data_q),
        .act_seen   (act_seen_q),
        .locked     (locked)
    );

    assign irq         = any_unmasked(pend_q, ctrl_q.mask);
    assign compress_en = ctrl_q.comp_en;
    assign auto_mode   = ctrl_q.auto_en;
endmodule

// File: rtl/pport_irq_chk.sv
module pport_irq_chk (
    input logic       clk,
    input logic       rst,
    input logic       reg_wr,
    input logic [1:0] reg_addr,
    input logic [7:0] reg_wdata,
    input logic [2:0] port_mode,
    input logic       bulk_out_empty,
    input logic [7:0] ctrl_v,
    input logic [4:0] pend_v,
    input logic [7:0] data_v,
    input logic       act_seen,
    input logic       locked,
    input logic       irq
);
    logic [4:0] clr_try;
    assign clr_try = (reg_wr && reg_addr == 2'd1) ? reg_wdata[4:0] : 5'd0;

    assert_lock_hold_R10: assert property (@(posedge clk) disable iff (rst)
        ($past(reg_wr) && $past(reg_addr) == 2'd2 && $past(locked)) |-> data_v == $past(data_v));

    assert_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        ((($past(pend_v) & ~$past(clr_try)) & ~pend_v) == 5'd0));

    assert_fault_mode_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(pend_v[0]) |-> $past(port_mode) == 3'b011);

    assert_bout_src_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(pend_v[1]) |-> $past(bulk_out_empty));

    assert_all_masked_R8: assert property (@(posedge clk) disable iff (rst)
        (ctrl_v[7:3] == 5'b11111) |-> !irq);

    assert_act_sticky_R11: assert property (@(posedge clk) disable iff (rst)
        $past(act_seen) |-> act_seen);
endmodule

bind pport_irq_ctrl pport_irq_chk u_chk (
    .clk            (clk),
    .rst            (rst),
    .reg_wr         (reg_wr),
    .reg_addr       (reg_addr),
    .reg_wdata      (reg_wdata),
    .port_mode      (port_mode),
    .bulk_out_empty (bulk_out_empty),
    .ctrl_v         (ctrl_q),
    .pend_v         (pend_q),
    .data_v         (data_q),
    .act_seen       (act_seen_q),
    .locked         (locked),
    .irq            (irq)
);

// File: tb/pport_irq_ctrl_tb.sv
module pport_irq_ctrl_tb;
    localparam int LINES = 5;
    localparam int FBIT  = 1;
    localparam int TMO   = 16;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             reg_wr = 1'b0;
    logic [1:0]       reg_addr = 2'd0;
    logic [7:0]       reg_wdata = 8'h00;
    logic [7:0]       reg_rdata;
    logic [2:0]       port_mode = 3'b000;
    logic [LINES-1:0] periph_lines = '0;
    logic             plh = 1'b0;
    logic             bulk_in = 1'b0;
    logic             bulk_out = 1'b0;
    logic             act = 1'b0;
    logic             irq;
    logic             compress_en;
    logic             auto_mode;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    pport_irq_ctrl #(.LINES(LINES), .FAULT_BIT(FBIT), .TIMEOUT(TMO)) u_dut (
        .clk (clk), .rst (rst), .reg_wr (reg_wr), .reg_addr (reg_addr),
        .reg_wdata (reg_wdata), .reg_rdata (reg_rdata), .port_mode (port_mode),
        .periph_lines (periph_lines), .periph_logic_high (plh),
        .bulk_in_avail (bulk_in), .bulk_out_empty (bulk_out),
        .auto_activity (act), .irq (irq), .compress_en (compress_en),
        .auto_mode (auto_mode)
    );

    function automatic logic exp_irq(input logic [4:0] pend, input logic [7:0] ctrl);
        return |(pend & ~ctrl[7:3]);
    endfunction

    task automatic chk(input string req, input logic [7:0] act_v, input logic [7:0] exp_v);
        n_cmp++;
        if (act_v !== exp_v) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act_v, exp_v);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        void'($urandom(32'd1284));
        step(4);
        rst = 1'b0;
        step(1);

        // R1 reset state
        rd(2'd0, v); chk("R1 ctrl", v, 8'hFB);
        rd(2'd1, v); chk("R1 pend", v, 8'h00);
        rd(2'd2, v); chk("R1 data", v, 8'h00);
        chk("R1 irq/outs", {5'd0, irq, compress_en, auto_mode}, 8'h03);

        // R10 locked in auto mode
        wr(2'd2, 8'h5A);
        rd(2'd2, v); chk("R10 data locked", v, 8'h00);
        bulk_in = 1'b1; step(1);
        rd(2'd1, v); chk("R6 bulk-in", v, 8'h04);
        wr(2'd1, 8'h1F);
        rd(2'd1, v); chk("R10 clear locked", v, 8'h04);
        chk("R8 masked irq", {7'd0, irq}, 8'h00);

        // Unlock
        wr(2'd0, 8'h00);
        rd(2'd0, v); chk("R2 ctrl 00", v, 8'h00);
        chk("R8 unmasked irq", {7'd0, irq}, 8'h01);
        wr(2'd2, 8'h5A);
        rd(2'd2, v); chk("R10 data unlocked", v, 8'h5A);
        wr(2'd1, 8'h04);
        rd(2'd1, v); chk("R9 clear", v, 8'h00);
        chk("R9 irq after clear", {7'd0, irq}, 8'h00);
        wr(2'd0, 8'hA4);
        rd(2'd0, v); chk("R2 ctrl A4", v, 8'hA4);
        chk("R2 outs", {6'd0, compress_en, auto_mode}, 8'h00);
        wr(2'd0, 8'h00);

        // R9 set beats clear
        bulk_out = 1'b1;
        wr(2'd1, 8'h02);
        rd(2'd1, v); chk("R9 set wins", v & 8'h02, 8'h02);
        wr(2'd1, 8'h1F);

        // R3 change on a line, rise then fall, and on logic-high
        periph_lines = 5'b10000;
        step(2); rd(2'd1, v); chk("R3 early", v, 8'h00);
        step(1); rd(2'd1, v); chk("R3 rise", v, 8'h08);
        wr(2'd1, 8'h1F);
        periph_lines = 5'b00000;
        step(3); rd(2'd1, v); chk("R3 fall", v, 8'h08);
        wr(2'd1, 8'h1F);
        plh = 1'b1;
        step(3); rd(2'd1, v); chk("R3 plh rise", v, 8'h08);
        wr(2'd1, 8'h1F);

        // R7 fault only in ECP mode
        periph_lines = 5'b00010; step(3); wr(2'd1, 8'h1F);
        periph_lines = 5'b00000;
        step(3); rd(2'd1, v); chk("R7 non-ECP", v, 8'h08);
        wr(2'd1, 8'h1F);
        port_mode = 3'b011;
        periph_lines = 5'b00010; step(3); wr(2'd1, 8'h1F);
        periph_lines = 5'b00000;
        step(3); rd(2'd1, v); chk("R7 ECP", v, 8'h09);
        wr(2'd1, 8'h1F);
        port_mode = 3'b000;

        // R4 logic-high fall
        plh = 1'b0;
        step(2); rd(2'd1, v); chk("R4 early", v & 8'h10, 8'h00);
        step(1); rd(2'd1, v); chk("R4 disc", v, 8'h18);
        wr(2'd1, 8'h1F);

        // R5 all-high timeout
        plh = 1'b1; periph_lines = '1;
        step(3);
        wr(2'd1, 8'h1F);
        step(TMO + 1 - 4);
        rd(2'd1, v); chk("R5 before", v & 8'h10, 8'h00);
        step(1);
        rd(2'd1, v); chk("R5 fire", v & 8'h10, 8'h10);
        wr(2'd1, 8'h1F);
        step(20);
        rd(2'd1, v); chk("R5 once", v, 8'h00);
        periph_lines = '0; step(4);
        wr(2'd1, 8'h1F);

        // R8 random masks over random bulk events
        for (int i = 0; i < 30; i++) begin
            logic b0, b1;
            logic [4:0] m;
            logic [4:0] ep;
            bulk_in = 1'b0; bulk_out = 1'b0; step(1);
            wr(2'd1, 8'h1F);
            b0 = 1'($urandom); b1 = 1'($urandom); m = 5'($urandom);
            bulk_in = b0; bulk_out = b1; step(1);
            wr(2'd0, {m, 3'b000});
            ep = {2'b00, b0, b1, 1'b0};
            rd(2'd1, v); chk("R8 pend", v, {3'b000, ep});
            chk("R8 irq", {7'd0, irq}, {7'd0, exp_irq(ep, {m, 3'b000})});
        end

        // R11 activity keeps the lock
        wr(2'd0, 8'h01);
        act = 1'b1; step(1); act = 1'b0;
        wr(2'd0, 8'h00);
        rd(2'd0, v); chk("R11 ctrl", v, 8'h00);
        wr(2'd2, 8'h33);
        rd(2'd2, v); chk("R11 data", v, 8'h5A);
        bulk_in = 1'b0; step(1); bulk_in = 1'b1; step(1);
        wr(2'd1, 8'h1F);
        rd(2'd1, v); chk("R11 clear", v & 8'h04, 8'h04);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule